// File: doc/BRIEF.md
# Programmable Clock-Channel Divider with Synchronous Restart

This block derives one output clock from a fast input clock. The high time and the low time of the output are programmed separately, each as a count of input clock cycles. An active-low chip-level synchronisation input can hold the divider and then restart it. Because every channel restarts with the same latency after the hold is released, channels with identical settings come out aligned. Each channel can also delay its restart by a programmed number of input cycles, choose whether its first phase is high or low, and choose to ignore the chip-level synchronisation.

Other per-channel settings give alternatives to the divided clock. Bypass sends the input clock straight to the output. Force-high gives a static high level, but only for a channel that ignores synchronisation. Power-down disables the output. All settings arrive as plain parallel inputs, and the block has no data stream. A new high or low count is loaded only when a phase begins, so changing a count never cuts a phase short.

Output priority, highest first: power-down, then bypass, then static high, then the divided level.

Top module: `clkdiv_channel`

## Requirements
- R1: In divide mode, every high phase of `div_clk_o` lasts `cfg_high + 1` input cycles, which gives 1 to 16 cycles.
- R2: In divide mode, every low phase of `div_clk_o` lasts `cfg_low + 1` input cycles, which gives 1 to 16 cycles.
- R3: Hold condition: `sync_n` is 0 and `cfg_ignore_sync` is 0. While it holds, the divider is held and, from the next rising edge onward, `div_clk_o` is 0 (the forced level is low).
- R4: Take rising edge 1 as the first edge that samples the hold as released. `div_clk_o` stays 0 after edges 1 to `cfg_phase`, and takes its start level at edge `cfg_phase + 1`.
- R5: The first phase after a restart is high when `cfg_start_high` is 1 and low when it is 0. After it, the phases alternate.
- R6: With `cfg_ignore_sync` at 1, `sync_n` has no effect: a running divider keeps its waveform.
- R7: With `cfg_force_high` and `cfg_ignore_sync` both at 1, `div_clk_o` is a static 1. With `cfg_ignore_sync` at 0, force-high has no effect and a held channel outputs 0.
- R8: With `cfg_bypass` at 1, `div_clk_o` follows `clk` and the divider is held. Clearing bypass restarts the divider with the same latency as in R4.
- R9: With `cfg_power_down` at 1, `out_en_o` is 0 and `div_clk_o` is 0. Otherwise `out_en_o` is 1.
- R10: A change to `cfg_high` or `cfg_low` takes effect at the next phase boundary. The phase in progress keeps the length it had when it began.
- R11: While `rst_n` is 0, `div_clk_o` is 0. A release from reset restarts the divider with the same latency as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Chip-level synchronisation, active low |
| cfg_high | input | CNT_W | High time minus one, in input cycles |
| cfg_low | input | CNT_W | Low time minus one, in input cycles |
| cfg_bypass | input | 1 | Route the input clock to the output |
| cfg_ignore_sync | input | 1 | Channel ignores `sync_n` |
| cfg_force_high | input | 1 | Static high output; needs `cfg_ignore_sync` |
| cfg_start_high | input | 1 | First phase after restart is high |
| cfg_phase | input | PHASE_W | Restart delay in input cycles |
| cfg_power_down | input | 1 | Disable the channel output |
| div_clk_o | output | 1 | Divided clock |
| out_en_o | output | 1 | Output enable |

## Verification
The divider is restarted with every start level combined with every restart delay, using random high and low counts. Each sample is compared against a period model, so one run separates latency errors from width errors and from start-level errors. Extreme settings (divide by two, 16/16, 1/16 and 16/1) show off-by-one faults at both ends of the count fields. A count change in the middle of a phase shows whether new counts are loaded at the boundary or at once. Separate runs give the restart by bypass exit, by reset release and by a released hold, and the waveform must be the same in each. A sync pulse on a channel that ignores sync must leave the waveform unchanged.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clkdiv_hold_ctl.sv
module clkdiv_hold_ctl (
  input  logic sync_n,
  input  logic cfg_bypass,
  input  logic cfg_ignore_sync,
  input  logic cfg_force_high,
  output logic hold_o,
  output logic static_hi_o
);
  logic sync_hold;

  // A channel that obeys sync is held while sync is low; bypass also parks it.
  always_comb begin
    sync_hold   = !sync_n && !cfg_ignore_sync;
    hold_o      = sync_hold || cfg_bypass;
    static_hi_o = cfg_force_high && cfg_ignore_sync;
  end
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [CNT_W-1:0]   cfg_high,
  input  logic [CNT_W-1:0]   cfg_low,
  input  logic               cfg_start_high,
  input  logic [PHASE_W-1:0] cfg_phase,
  output logic               lvl_o,
  output seq_state_e         state_o
);
  localparam logic [PHASE_W-1:0] WAIT_ONE = PHASE_W'(1);

  seq_state_e         state_q;
  logic               lvl_q;
  logic [CNT_W-1:0]   run_cnt_q;
  logic [CNT_W-1:0]   len_q;
  logic [PHASE_W-1:0] wait_cnt_q;
  logic [CNT_W-1:0]   start_len;

  // The length of a phase is captured at the moment the phase begins.
  always_comb start_len = cfg_start_high ? cfg_high : cfg_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_HOLD;
      lvl_q      <= 1'b0;
      run_cnt_q  <= '0;
      len_q      <= '0;
      wait_cnt_q <= '0;
    end else if (hold) begin
      state_q    <= SEQ_HOLD;
      lvl_q      <= 1'b0;
      run_cnt_q  <= '0;
      wait_cnt_q <= '0;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          if (cfg_phase == '0) begin
            state_q   <= SEQ_RUN;
            lvl_q     <= cfg_start_high;
            run_cnt_q <= '0;
            len_q     <= start_len;
          end else begin
            state_q    <= SEQ_WAIT;
            wait_cnt_q <= WAIT_ONE;
          end
        end
        SEQ_WAIT: begin
          if (wait_cnt_q >= cfg_phase) begin
            state_q   <= SEQ_RUN;
            lvl_q     <= cfg_start_high;
            run_cnt_q <= '0;
            len_q     <= start_len;
          end else begin
            wait_cnt_q <= wait_cnt_q + WAIT_ONE;
          end
        end
        SEQ_RUN: begin
          if (run_cnt_q == len_q) begin
            lvl_q     <= ~lvl_q;
            run_cnt_q <= '0;
            len_q     <= lvl_q ? cfg_low : cfg_high;
          end else begin
            run_cnt_q <= run_cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_q <= SEQ_HOLD;
          lvl_q   <= 1'b0;
        end
      endcase
    end
  end

  assign lvl_o   = lvl_q;
  assign state_o = state_q;
endmodule

// File: rtl/clkdiv_out_mux.sv
module clkdiv_out_mux (
  input  logic clk,
  input  logic lvl,
  input  logic static_hi,
  input  logic bypass,
  input  logic power_down,
  output logic div_clk_o,
  output logic out_en_o
);
  always_comb begin
    out_en_o = !power_down;
    if (power_down)     div_clk_o = 1'b0;
    else if (bypass)    div_clk_o = clk;
    else if (static_hi) div_clk_o = 1'b1;
    else                div_clk_o = lvl;
  end
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic [CNT_W-1:0]   cfg_high,
  input  logic [CNT_W-1:0]   cfg_low,
  input  logic               cfg_bypass,
  input  logic               cfg_ignore_sync,
  input  logic               cfg_force_high,
  input  logic               cfg_start_high,
  input  logic [PHASE_W-1:0] cfg_phase,
  input  logic               cfg_power_down,
  output logic               div_clk_o,
  output logic               out_en_o
);
  logic       hold;
  logic       static_hi;
  logic       seq_lvl;
  seq_state_e seq_state;

  clkdiv_hold_ctl u_hold (
    .sync_n          (sync_n),
    .cfg_bypass      (cfg_bypass),
    .cfg_ignore_sync (cfg_ignore_sync),
    .cfg_force_high  (cfg_force_high),
    .hold_o          (hold),
    .static_hi_o     (static_hi)
  );

  clkdiv_seq #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold           (hold),
    .cfg_high       (cfg_high),
    .cfg_low        (cfg_low),
    .cfg_start_high (cfg_start_high),
    .cfg_phase      (cfg_phase),
    .lvl_o          (seq_lvl),
    .state_o        (seq_state)
  );

  clkdiv_out_mux u_mux (
    .clk        (clk),
    .lvl        (seq_lvl),
    .static_hi  (static_hi),
    .bypass     (cfg_bypass),
    .power_down (cfg_power_down),
    .div_clk_o  (div_clk_o),
    .out_en_o   (out_en_o)
  );
endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_n,
  input logic       cfg_bypass,
  input logic       cfg_ignore_sync,
  input logic       cfg_force_high,
  input logic       cfg_power_down,
  input logic       div_clk_o,
  input logic       out_en_o,
  input logic       seq_lvl,
  input seq_state_e seq_state
);
  localparam int MAX_LEN = 1 << CNT_W;
  localparam int RUN_W   = $clog2(MAX_LEN + 2) + 1;

  logic             lvl_prev_q;
  logic [RUN_W-1:0] run_len_q;

  // Counts how many cycles the level has stayed the same while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      run_len_q  <= '0;
    end else begin
      lvl_prev_q <= seq_lvl;
      if (seq_state != SEQ_RUN)          run_len_q <= '0;
      else if (seq_lvl != lvl_prev_q)    run_len_q <= RUN_W'(1);
      else if (run_len_q < RUN_W'(MAX_LEN + 1)) run_len_q <= run_len_q + RUN_W'(1);
    end
  end

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_power_down |-> (!div_clk_o && !out_en_o));

  // R3
  sync_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !cfg_ignore_sync && !cfg_bypass) |=>
      (div_clk_o == 1'b0 || cfg_bypass || cfg_power_down ||
       (cfg_force_high && cfg_ignore_sync)));

  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_force_high && cfg_ignore_sync && !cfg_bypass && !cfg_power_down)
      |-> div_clk_o);

  // R1 R2
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len_q <= RUN_W'(MAX_LEN));

  // R4
  wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_WAIT) |-> !seq_lvl);
endmodule

bind clkdiv_channel clkdiv_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sync_n          (sync_n),
  .cfg_bypass      (cfg_bypass),
  .cfg_ignore_sync (cfg_ignore_sync),
  .cfg_force_high  (cfg_force_high),
  .cfg_power_down  (cfg_power_down),
  .div_clk_o       (div_clk_o),
  .out_en_o        (out_en_o),
  .seq_lvl         (seq_lvl),
  .seq_state       (seq_state)
);

// File: tb/clkdiv_channel_bench.sv
module clkdiv_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic [3:0] cfg_high = '0;
  logic [3:0] cfg_low = '0;
  logic       cfg_bypass = 1'b0;
  logic       cfg_ignore_sync = 1'b0;
  logic       cfg_force_high = 1'b0;
  logic       cfg_start_high = 1'b0;
  logic [3:0] cfg_phase = '0;
  logic       cfg_power_down = 1'b0;
  logic       div_clk_o;
  logic       out_en_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_channel u_clkdiv_channel (
    .clk (clk), .rst_n (rst_n), .sync_n (sync_n),
    .cfg_high (cfg_high), .cfg_low (cfg_low), .cfg_bypass (cfg_bypass),
    .cfg_ignore_sync (cfg_ignore_sync), .cfg_force_high (cfg_force_high),
    .cfg_start_high (cfg_start_high), .cfg_phase (cfg_phase),
    .cfg_power_down (cfg_power_down), .div_clk_o (div_clk_o), .out_en_o (out_en_o)
  );

  // Model: level after rising edge n, where edge 1 first sees the release.
  function automatic logic exp_lvl(int n, int hi, int lo, int st, int ph);
    int m, lh, ll, per, first;
    if (n <= ph) return 1'b0;
    m = n - ph - 1;
    lh = hi + 1;
    ll = lo + 1;
    per = lh + ll;
    first = (st != 0) ? lh : ll;
    if ((m % per) < first) return logic'(st != 0);
    return logic'(st == 0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_for(int n, int ph, logic e, bit ign_zone);
    if (ign_zone) return "R6";
    if (n <= ph) return "R4";
    if (n == ph + 1) return "R5";
    return e ? "R1" : "R2";
  endfunction

  // Sample after edges 1..len; optionally pull sync low under ignore after edge 4.
  task automatic follow(int hi, int lo, int st, int ph, int len, bit ign_pulse, string over);
    for (int n = 1; n <= len; n++) begin
      logic e;
      @(posedge clk); #2;
      e = exp_lvl(n, hi, lo, st, ph);
      if (over != "") check(over, div_clk_o, e);
      else check(tag_for(n, ph, e, ign_pulse && n > 4), div_clk_o, e);
      if (ign_pulse && n == 4) begin
        @(negedge clk);
        cfg_ignore_sync = 1'b1;
        sync_n = 1'b0;
      end
    end
  endtask

  task automatic run_case(int hi, int lo, int st, int ph, bit by_bypass, bit ign_pulse);
    int len;
    @(negedge clk);
    cfg_ignore_sync = 1'b0;
    cfg_force_high = 1'b0;
    cfg_high = 4'(hi);
    cfg_low = 4'(lo);
    cfg_start_high = st[0];
    cfg_phase = 4'(ph);
    if (by_bypass) begin
      sync_n = 1'b1;
      cfg_bypass = 1'b1;
    end else begin
      sync_n = 1'b0;
      cfg_bypass = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      if (by_bypass) check("R8", div_clk_o, 1'b1);
      else check("R3", div_clk_o, 1'b0);
    end
    @(negedge clk);
    if (by_bypass) cfg_bypass = 1'b0;
    else sync_n = 1'b1;
    len = ph + 1 + 2 * (hi + lo + 2) + 2;
    follow(hi, lo, st, ph, len, ign_pulse, by_bypass ? "R8" : "");
    @(negedge clk);
    cfg_ignore_sync = 1'b0;
    sync_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    // R11: reset state
    @(posedge clk); #2;
    check("R11", div_clk_o, 1'b0);
    check("R11", out_en_o, 1'b1);
    cfg_high = 4'd2; cfg_low = 4'd1; cfg_start_high = 1'b1; cfg_phase = 4'd2;
    @(negedge clk);
    rst_n = 1'b1;
    follow(2, 1, 1, 2, 16, 1'b0, "R11");

    // R4 R5 R1 R2: every start level with every delay, random counts
    for (int st = 0; st < 2; st++) begin
      for (int ph = 0; ph < 16; ph++) begin
        int hi, lo;
        hi = int'($urandom % 16);
        lo = int'($urandom % 16);
        run_case(hi, lo, st, ph, 1'b0, 1'b0);
      end
    end
    // Boundary counts
    run_case(0, 0, 0, 0, 1'b0, 1'b0);
    run_case(15, 15, 1, 15, 1'b0, 1'b0);
    run_case(0, 15, 1, 3, 1'b0, 1'b0);
    run_case(15, 0, 0, 7, 1'b0, 1'b0);
    // R6: sync pulse ignored
    run_case(2, 4, 1, 2, 1'b0, 1'b1);
    // R8: restart on bypass exit
    run_case(3, 1, 0, 5, 1'b1, 1'b0);

    // R10: counts changed mid-phase
    @(negedge clk);
    cfg_high = 4'd5; cfg_low = 4'd5; cfg_start_high = 1'b1; cfg_phase = 4'd0;
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    for (int n = 1; n <= 14; n++) begin
      logic e;
      @(posedge clk); #2;
      e = (n <= 6) ? 1'b1 : (n <= 9) ? 1'b0 : (n <= 11) ? 1'b1 : 1'b0;
      check("R10", div_clk_o, e);
      if (n == 2) begin
        @(negedge clk);
        cfg_high = 4'd1;
        cfg_low = 4'd2;
      end
    end

    // R7: force-high without ignore gives low under hold
    @(negedge clk);
    cfg_force_high = 1'b1; cfg_ignore_sync = 1'b0; sync_n = 1'b0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check("R7", div_clk_o, 1'b0);
    // R7: static high with ignore, regardless of sync
    @(negedge clk);
    cfg_ignore_sync = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2; check("R7", div_clk_o, 1'b1);
      @(negedge clk); #2; check("R7", div_clk_o, 1'b1);
      sync_n = ~sync_n;
    end
    @(negedge clk);
    cfg_force_high = 1'b0; cfg_ignore_sync = 1'b0; sync_n = 1'b1;

    // R8: clock passes through
    @(negedge clk);
    cfg_bypass = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2; check("R8", div_clk_o, 1'b1);
      @(negedge clk); #2; check("R8", div_clk_o, 1'b0);
    end
    @(negedge clk);
    cfg_bypass = 1'b0;
    cfg_high = 4'd1; cfg_low = 4'd1;

    // R9: power-down over a running divider and over bypass
    repeat (3) @(negedge clk);
    cfg_power_down = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      check("R9", div_clk_o, 1'b0);
      check("R9", out_en_o, 1'b0);
      @(negedge clk); #2;
      check("R9", div_clk_o, 1'b0);
      if (k == 1) cfg_bypass = 1'b1;
    end
    @(negedge clk);
    cfg_power_down = 1'b0; cfg_bypass = 1'b0;
    @(posedge clk); #2;
    check("R9", out_en_o, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule